// File: doc/BRIEF.md
# DMA Global Control and Interrupt Arbiter

This block is the shared front end of a ten-channel DMA controller. It keeps three registers on a plain 32-bit register bus: a global control word (master enable and a memory-drain field), a global halt-mask word, and a combined interrupt status/mask word. The per-channel transfer engines are not part of the block. Each engine presents its start bit as a request, receives a one-hot service grant, reports completion with a done pulse, and gets back a stop pulse that tells it to clear its own start bit.

A round-robin pointer steps through the channels in rising order, one channel per clock, whenever the controller is enabled and not halted. If the channel under the pointer is requesting, that channel gets a grant on the next cycle. The pointer moves on after every examination and keeps its position across pauses. Completion pulses set status bits. When any status bit meets its mask bit, the CPU interrupt line goes high. If the memory-drain field is non-zero, a granted channel is completed on the spot.

Top module: `dma_ctl_top`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0, the halt-mask word reads 0x0000_1201, `cpu_irq` is low and no grant is issued. Register offsets: 0 is control, 1 is status/mask, 2 is halt-mask. Any other offset reads 0.
- R2: Control bit 0 is the master enable. While it is 0, no grant is issued.
- R3: While bit 16 of the halt-mask word is 1, no grant is issued. The halt-mask word reads back as written.
- R4: On every clock where the controller is active, the pointer examines one channel, starting at 0 and rising. If that channel's `ch_req` bit is set, the channel's bit is the only bit set in `ch_grant` on the following cycle. The pointer wraps from 9 to 0. Channels that are not requesting are passed over.
- R5: The pointer stays where it is while the controller is inactive, and examination resumes from that channel afterwards.
- R6: A `ch_done[n]` pulse raises `ch_stop[n]` in the same cycle and sets status bit n from the next cycle onward.
- R7: A write to offset 1 clears every status bit in 14:0 that is written as 1 and leaves the other status bits unchanged.
- R8: The same write toggles every mask bit whose bit in 30:16 is written as 1. Mask bits written as 0 keep their value.
- R9: Reading offset 1 returns the status bits in 14:0 and the mask bits in 30:16. Bits 15 and 31 read as 0.
- R10: `cpu_irq` is high exactly when some status bit and its mask bit are both 1.
- R11: When control bits 3:2 are non-zero, a granted channel receives `ch_stop` in its grant cycle, and its status bit is set on the next cycle.
- R12: If a done pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ch_req | input | 10 | Per-channel start bits |
| ch_grant | output | 10 | One-hot service grant |
| ch_done | input | 10 | Per-channel completion pulses |
| ch_stop | output | 10 | Per-channel start-bit clear pulses |
| cpu_irq | output | 1 | Interrupt to the CPU |

## Verification
The checker watches the grant output on every cycle. It must be one-hot or empty, it must follow a request seen on the previous cycle, and it must stay silent whenever the enable was off or the halt bit was set on the previous cycle. The checker also confirms that each done pulse leaves its status bit set and that the mask does not move unless a status-word write occurs. Other behaviour depends on the history of the registers and the pointer, so only the bench scenarios can show it: the exact round-robin order across the wrap, the pointer resuming after a pause, the clear-versus-toggle meaning of a single status write, set-wins-over-clear, and drain-forced completion.

// File: rtl/dmac_ctl_pkg.sv
package dmac_ctl_pkg;
   // register offsets on the control bus
   localparam int OFS_CTRL  = 0;
   localparam int OFS_STAT  = 1;
   localparam int OFS_DMASK = 2;

   // control word fields
   localparam int CTRL_EN_BIT    = 0;
   localparam int CTRL_DRAIN_LSB = 2;
   localparam int CTRL_DRAIN_W   = 2;

   // status word: mask half starts here
   localparam int MASK_LSB = 16;
endpackage

// File: rtl/dmac_glob_regs.sv
module dmac_glob_regs
   import dmac_ctl_pkg::*;
#(
   parameter int             DW        = 32,
   parameter int             AW        = 2,
   parameter logic [DW-1:0]  DMASK_RST = DW'(32'h1201),
   parameter int             HALT_BIT  = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] ctrl_q,
   output logic [DW-1:0] dmask_q,
   output logic          active,
   output logic          drain_on
);
   logic wr_ctrl, wr_dmask;

   assign wr_ctrl  = wr_en && (addr == AW'(OFS_CTRL));
   assign wr_dmask = wr_en && (addr == AW'(OFS_DMASK));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         dmask_q <= DMASK_RST;
      end else begin
         if (wr_ctrl)  ctrl_q  <= wdata;
         if (wr_dmask) dmask_q <= wdata;
      end
   end

   assign active   = ctrl_q[CTRL_EN_BIT] & ~dmask_q[HALT_BIT];
   assign drain_on = |ctrl_q[CTRL_DRAIN_LSB +: CTRL_DRAIN_W];
endmodule

// File: rtl/dmac_rr_arb.sv
module dmac_rr_arb #(
   parameter  int NCH = 10,
   localparam int PW  = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           active,
   input  logic [NCH-1:0] req,
   output logic [NCH-1:0] grant_q
);
   logic [PW-1:0] ptr_q;
   logic [PW-1:0] ptr_nx;

   generate
      if ((1 << PW) == NCH) begin : g_pow2
         assign ptr_nx = ptr_q + PW'(1);
      end else begin : g_wrap
         assign ptr_nx = (ptr_q == PW'(NCH - 1)) ? '0 : ptr_q + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q   <= '0;
         grant_q <= '0;
      end else begin
         grant_q <= '0;
         if (active) begin
            if (req[ptr_q]) grant_q <= NCH'(1) << ptr_q;
            ptr_q <= ptr_nx;
         end
      end
   end
endmodule

// File: rtl/dmac_int_ctl.sv
module dmac_int_ctl
   import dmac_ctl_pkg::*;
#(
   parameter int NCH = 10,
   parameter int SW  = 15,
   parameter int DW  = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           stat_wr,
   input  logic [DW-1:0]  wdata,
   input  logic [NCH-1:0] fin,
   output logic [SW-1:0]  status_q,
   output logic [SW-1:0]  mask_q,
   output logic           irq
);
   logic [SW-1:0] set_v, clr_v, tog_v;

   generate
      for (genvar i = 0; i < SW; i++) begin : g_set
         if (i < NCH) begin : g_live
            assign set_v[i] = fin[i];
         end else begin : g_tie
            assign set_v[i] = 1'b0;
         end
      end
   endgenerate

   assign clr_v = stat_wr ? wdata[SW-1:0]          : '0;
   assign tog_v = stat_wr ? wdata[MASK_LSB +: SW]  : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         mask_q   <= '0;
      end else begin
         status_q <= (status_q & ~clr_v) | set_v;
         mask_q   <= mask_q ^ tog_v;
      end
   end

   assign irq = |(status_q & mask_q);
endmodule

// File: rtl/dma_ctl_top.sv
module dma_ctl_top
   import dmac_ctl_pkg::*;
#(
   parameter int                 NUM_CH    = 10,
   parameter int                 DATA_W    = 32,
   parameter int                 REG_AW    = 2,
   parameter int                 STAT_W    = 15,
   parameter logic [DATA_W-1:0]  DMASK_RST = DATA_W'(32'h1201),
   parameter int                 HALT_BIT  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NUM_CH-1:0] ch_req,
   output logic [NUM_CH-1:0] ch_grant,
   input  logic [NUM_CH-1:0] ch_done,
   output logic [NUM_CH-1:0] ch_stop,
   output logic              cpu_irq
);
   generate
      if (NUM_CH < 2 || NUM_CH > STAT_W) begin : g_bad_nch
         $error("NUM_CH must lie between 2 and STAT_W");
      end
      if (DATA_W < MASK_LSB + STAT_W) begin : g_bad_dw
         $error("DATA_W too narrow for status and mask halves");
      end
      if (HALT_BIT >= DATA_W) begin : g_bad_halt
         $error("HALT_BIT outside the data word");
      end
   endgenerate

   logic [DATA_W-1:0] ctrl_q, dmask_q;
   logic              active, drain_on;
   logic [STAT_W-1:0] status_q, mask_q;
   logic              stat_wr;
   logic [NUM_CH-1:0] fin;
   logic [DATA_W-1:0] stat_word;

   dmac_glob_regs #(
      .DW(DATA_W), .AW(REG_AW), .DMASK_RST(DMASK_RST), .HALT_BIT(HALT_BIT)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
      .wdata(reg_wdata), .ctrl_q(ctrl_q), .dmask_q(dmask_q),
      .active(active), .drain_on(drain_on)
   );

   dmac_rr_arb #(.NCH(NUM_CH)) arb_i (
      .clk(clk), .rst_n(rst_n), .active(active), .req(ch_req),
      .grant_q(ch_grant)
   );

   assign stat_wr = reg_wr_en && (reg_addr == REG_AW'(OFS_STAT));
   assign fin     = ch_done | (drain_on ? ch_grant : '0);
   assign ch_stop = fin;

   dmac_int_ctl #(.NCH(NUM_CH), .SW(STAT_W), .DW(DATA_W)) intc_i (
      .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr), .wdata(reg_wdata),
      .fin(fin), .status_q(status_q), .mask_q(mask_q), .irq(cpu_irq)
   );

   always_comb begin
      stat_word                      = '0;
      stat_word[STAT_W-1:0]          = status_q;
      stat_word[MASK_LSB +: STAT_W]  = mask_q;
      case (reg_addr)
         REG_AW'(OFS_CTRL):  reg_rdata = ctrl_q;
         REG_AW'(OFS_STAT):  reg_rdata = stat_word;
         REG_AW'(OFS_DMASK): reg_rdata = dmask_q;
         default:            reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/dmac_ctl_chk.sv
module dmac_ctl_chk #(
   parameter int NCH      = 10,
   parameter int SW       = 15,
   parameter int DW       = 32,
   parameter int HALT_BIT = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NCH-1:0] ch_req,
   input logic [NCH-1:0] ch_grant,
   input logic [NCH-1:0] ch_done,
   input logic [DW-1:0]  ctrl_q,
   input logic [DW-1:0]  dmask_q,
   input logic [SW-1:0]  status_q,
   input logic [SW-1:0]  mask_q,
   input logic           stat_wr
);
   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_grant)); // R4

   AST_GRANT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_grant != '0) |-> ((ch_grant & $past(ch_req)) == ch_grant)); // R4

   AST_NO_GRANT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ctrl_q[0]) |-> (ch_grant == '0)); // R2

   AST_NO_GRANT_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(dmask_q[HALT_BIT]) |-> (ch_grant == '0)); // R3

   AST_DONE_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_done != '0) |=> ((status_q[NCH-1:0] & $past(ch_done)) == $past(ch_done))); // R6

   AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_wr |=> $stable(mask_q)); // R8
endmodule

bind dma_ctl_top dmac_ctl_chk #(
   .NCH(NUM_CH), .SW(STAT_W), .DW(DATA_W), .HALT_BIT(HALT_BIT)
) chk_i (
   .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_grant(ch_grant),
   .ch_done(ch_done), .ctrl_q(ctrl_q), .dmask_q(dmask_q),
   .status_q(status_q), .mask_q(mask_q), .stat_wr(stat_wr)
);

// File: tb/dma_ctl_top_tb_top.sv
module dma_ctl_top_tb_top;
   localparam int NCH = 10;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            reg_wr_en = 1'b0;
   logic [1:0]      reg_addr = '0;
   logic [31:0]     reg_wdata = '0;
   logic [31:0]     reg_rdata;
   logic [NCH-1:0]  tb_req = '0;
   logic [NCH-1:0]  ch_grant;
   logic [NCH-1:0]  tb_done = '0;
   logic [NCH-1:0]  ch_stop;
   logic            cpu_irq;

   int    total = 0;
   int    bad = 0;
   int    gr_seen = 0;
   int    tb_ptr = 0;
   bit    tb_active = 0;
   bit    tb_drain = 0;
   logic [31:0] tb_ctrl = '0;
   logic [31:0] tb_dmask = 32'h1201;
   string cur_tag = "R4";
   int    exp_q[$];

   always #5 clk = ~clk;

   dma_ctl_top dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_req(tb_req),
      .ch_grant(ch_grant), .ch_done(tb_done), .ch_stop(ch_stop),
      .cpu_irq(cpu_irq)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      #1;
      reg_wr_en = 1'b0;
      if (a == 2'd0) tb_ctrl = d;
      if (a == 2'd2) tb_dmask = d;
      tb_active = tb_ctrl[0] && !tb_dmask[16];
      tb_drain  = tb_ctrl[3:2] != 2'b00;
   endtask

   task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(reg_rdata == exp, tag, reg_rdata, exp);
   endtask

   task automatic irq_is(input bit exp, input string tag);
      #1;
      chk(cpu_irq == exp, tag, {31'd0, cpu_irq}, {31'd0, exp});
   endtask

   task automatic run_req(input logic [NCH-1:0] r, input int n, input string tag);
      @(negedge clk);
      cur_tag = tag;
      tb_req = r;
      repeat (n) @(negedge clk);
      tb_req = '0;
      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, {tag, " all expected grants seen"}, exp_q.size(), 0);
   endtask

   // predictor: each active clock examines one channel in rising order (R4, R5)
   always @(posedge clk) begin
      if (rst_n && tb_active) begin
         if (tb_req[tb_ptr]) exp_q.push_back(tb_ptr);
         tb_ptr = (tb_ptr == NCH - 1) ? 0 : tb_ptr + 1;
      end
   end

   // monitor: compares grants with the queue and stop pulses with done/drain
   always begin
      @(negedge clk);
      #2;
      if (rst_n) begin
         if (ch_grant != '0 || tb_done != '0) begin
            logic [NCH-1:0] exp_stop;
            exp_stop = tb_done | (tb_drain ? ch_grant : '0);
            chk(ch_stop == exp_stop, "R6 R11 stop pulse", 32'(ch_stop), 32'(exp_stop));
         end
         if (ch_grant != '0) begin
            gr_seen++;
            if ($countones(ch_grant) != 1) begin
               chk(1'b0, "R4 grant not one-hot", 32'(ch_grant), 0);
            end else if (exp_q.size() == 0) begin
               chk(1'b0, "R2 R3 R4 unexpected grant", 32'(ch_grant), 0);
            end else begin
               int e;
               e = exp_q.pop_front();
               chk(ch_grant == (NCH'(1) << e), cur_tag, 32'(ch_grant), 32'(NCH'(1) << e));
            end
         end
      end
   end

   initial begin
      #2_000_000;
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int g0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(2'd0, 32'h0, "R1 control after reset");
      rd(2'd1, 32'h0, "R1 status after reset");
      rd(2'd2, 32'h0000_1201, "R1 halt-mask after reset");
      rd(2'd3, 32'h0, "R1 unused offset");
      irq_is(1'b0, "R1 irq after reset");
      chk(ch_grant == '0, "R1 no grant after reset", 32'(ch_grant), 0);

      // R2 disabled: requests ignored
      g0 = gr_seen;
      @(negedge clk); tb_req = '1;
      repeat (6) @(negedge clk);
      tb_req = '0;
      @(negedge clk);
      chk(gr_seen == g0, "R2 no grant while disabled", gr_seen - g0, 0);

      // R4 rising order, skipping, wrap
      wr(2'd0, 32'h1);
      run_req(10'b10_0010_0101, 25, "R4 sparse order");
      run_req(10'b00_0000_1000, 22, "R4 single channel");

      // R3 halt bit
      wr(2'd2, 32'h0001_1201);
      rd(2'd2, 32'h0001_1201, "R3 halt-mask readback");
      g0 = gr_seen;
      @(negedge clk); tb_req = '1;
      repeat (6) @(negedge clk);
      tb_req = '0;
      @(negedge clk);
      chk(gr_seen == g0, "R3 no grant while halted", gr_seen - g0, 0);

      // R5 resume from held pointer
      wr(2'd2, 32'h0000_1201);
      run_req('1, 13, "R5 resume order");
      wr(2'd0, 32'h0);

      // R6 done pulses on channels 4 and 7
      @(negedge clk); tb_done = 10'h090;
      #1; chk(ch_stop == 10'h090, "R6 stop with done", 32'(ch_stop), 32'h90);
      @(negedge clk); tb_done = '0;
      rd(2'd1, 32'h0000_0090, "R6 R9 status bits set");
      irq_is(1'b0, "R10 irq low without mask");

      wr(2'd1, 32'h0010_0000);
      rd(2'd1, 32'h0010_0090, "R8 mask bit 4 toggled on");
      irq_is(1'b1, "R10 irq high");

      wr(2'd1, 32'h0090_0000);
      rd(2'd1, 32'h0080_0090, "R8 toggle 4 off 7 on");
      irq_is(1'b1, "R10 irq via bit 7");

      wr(2'd1, 32'h0000_0080);
      rd(2'd1, 32'h0080_0010, "R7 clear bit 7 only");
      irq_is(1'b0, "R10 irq low after clear");

      // R12 done and clear on the same bit in the same cycle
      @(negedge clk);
      tb_done = 10'h080;
      reg_wr_en = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h0000_0090;
      @(posedge clk); #1;
      reg_wr_en = 1'b0;
      @(negedge clk); tb_done = '0;
      rd(2'd1, 32'h0080_0080, "R12 set wins over clear");
      irq_is(1'b1, "R10 R12 irq");

      wr(2'd1, 32'hFFFF_FFFF);
      rd(2'd1, 32'h7F7F_0000, "R7 R8 R9 all-ones write");
      irq_is(1'b0, "R10 irq after clear-all");
      wr(2'd1, 32'h7F7F_0000);
      rd(2'd1, 32'h0, "R8 mask back to zero");

      // R11 drain forces completion
      wr(2'd0, 32'h0000_0005);
      rd(2'd0, 32'h0000_0005, "R11 control readback");
      run_req(10'b00_0100_0000, 12, "R11 drain grant");
      wr(2'd0, 32'h0);
      rd(2'd1, 32'h0000_0040, "R11 drained channel status");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule